// File: doc/BRIEF.md
# SYSREF Assertion Counter and Reset Distributor

This block takes an alignment request from two sources and turns each new request into one-cycle reset strobes for three consumers: a clock divider, an NCO phase accumulator and a JESD LMFC counter. The first source is an asynchronous pin, which is synchronized before its rising edge is detected. The second is an assert bit in a small configuration register, and its 0-to-1 changes are detected against a delayed copy. When both sources rise in the same cycle, the block counts one assertion, not two.

The block counts assertions in a counter that saturates. The divider is reset on every assertion. The NCO and LMFC resets are held back until two assertions have been seen, so the phase of those consumers is only reset once the divider path has settled. Each path has a mask bit, so system software can freeze the divider after its first alignment and stop later NCO/LMFC resets once alignment is done. A synchronous soft-clear input returns the counter to zero so the sequence can be run again.

Top module: `sysref_distrib`

## Requirements
- R1: During and after a synchronous reset, all three strobes are 0, the assertion count is 0 and the configuration register (assert bit and both masks) is 0.
- R2: A rising edge of the pin is one assertion. The divider strobe goes high at the third falling clock edge after the pin is driven high, which is two cycles after the first rising edge that samples it high. A pin held high is one assertion only.
- R3: A configuration write (cfg_wr high) loads cfg_wdata, with bit 0 as the assert bit, bit 1 as the divider mask and bit 2 as the NCO/LMFC mask. A 0-to-1 change of the assert bit is one assertion, and its divider strobe is high in the second cycle after the write edge. A write that leaves the bit at 1, or that clears it, is not an assertion.
- R4: Every assertion gives one divider strobe unless the divider mask is set. Masked assertions are still counted.
- R5: The NCO and LMFC strobes do not fire for the first and second assertions after reset or soft clear.
- R6: The NCO and LMFC strobes fire together on the third assertion and on every later one.
- R7: While the NCO/LMFC mask is set, neither the NCO strobe nor the LMFC strobe fires. The assertion is still counted and still resets the divider.
- R8: The assertion count saturates at 3 and never wraps.
- R9: cnt_clr returns the count to 0. An assertion in the same cycle as cnt_clr is counted as the first assertion after the clear.
- R10: A pin rise and an assert-bit rise that reach the detector in the same cycle count as a single assertion with a single divider strobe.
- R11: Every strobe is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sysref_pin | input | 1 | Asynchronous alignment request pin |
| cfg_wr | input | 1 | Configuration register write enable |
| cfg_wdata | input | 3 | {nco mask, divider mask, assert bit} |
| cnt_clr | input | 1 | Synchronous soft clear of the assertion count |
| div_rst_o | output | 1 | Clock-divider reset strobe |
| nco_rst_o | output | 1 | NCO phase reset strobe |
| lmfc_rst_o | output | 1 | LMFC counter reset strobe |
| asrt_count | output | 2 | Saturating assertion count |

## Verification
The pin path is one stage longer than the register path. Because of this, a pin rise and an assert-bit write can arrive at the combine point in the same cycle. The bench sets up that collision by writing the register exactly one cycle after driving the pin high. It then counts the divider strobes and the count increments: exactly one of each is expected. A second collision comes from raising cnt_clr in the same cycle that a register-triggered assertion is detected, when the count was already saturated. The count must read 1 afterwards, the divider must pulse, and the NCO and LMFC strobes must stay low.

// File: rtl/sysref_pkg.sv
package sysref_pkg;
  localparam int CFG_W = 3;

  typedef struct packed {
    logic mask_nco;
    logic mask_div;
    logic assert_bit;
  } sref_cfg_t;
endpackage

// File: rtl/sref_pin_sync.sv
module sref_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  a_r2_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sref_bit_edge.sv
module sref_bit_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic dly_q;

  always_ff @(posedge clk) begin
    if (rst) dly_q <= 1'b0;
    else     dly_q <= level_i;
  end

  assign rise_o = level_i & ~dly_q;

  a_r3_bit_rise_once: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sref_count.sv
module sref_count #(
  parameter int SKIP  = 2,
  localparam int CNT_MAX = SKIP + 1,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             hit_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    base   = clr_i ? '0 : cnt_q;
    pass_o = hit_i && (base >= CNT_W'(SKIP));
    cnt_d  = base;
    if (hit_i && (base != CNT_W'(CNT_MAX))) cnt_d = base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(CNT_MAX)) && !clr_i |=> cnt_q == CNT_W'(CNT_MAX));
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q <= CNT_W'(1));
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sysref_distrib.sv
module sysref_distrib #(
  parameter int SYNC_STAGES = 2,
  parameter int NCO_SKIP    = 2,
  localparam int CNT_W      = $clog2(NCO_SKIP + 2)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sysref_pin,
  input  logic                        cfg_wr,
  input  logic [sysref_pkg::CFG_W-1:0] cfg_wdata,
  input  logic                        cnt_clr,
  output logic                        div_rst_o,
  output logic                        nco_rst_o,
  output logic                        lmfc_rst_o,
  output logic [CNT_W-1:0]            asrt_count
);
  import sysref_pkg::*;

  sref_cfg_t  cfg_q;
  logic       pin_rise;
  logic       bit_rise;
  logic       hit;
  logic       pass;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_wr) cfg_q <= sref_cfg_t'(cfg_wdata);
  end

  sref_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst(rst), .pin_i(sysref_pin), .rise_o(pin_rise)
  );

  sref_bit_edge u_bit (
    .clk(clk), .rst(rst), .level_i(cfg_q.assert_bit), .rise_o(bit_rise)
  );

  assign hit = pin_rise | bit_rise;

  sref_count #(.SKIP(NCO_SKIP)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .hit_i(hit),
    .pass_o(pass), .cnt_o(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_rst_o  <= 1'b0;
      nco_rst_o  <= 1'b0;
      lmfc_rst_o <= 1'b0;
    end else begin
      div_rst_o  <= hit  & ~cfg_q.mask_div;
      nco_rst_o  <= pass & ~cfg_q.mask_nco;
      lmfc_rst_o <= pass & ~cfg_q.mask_nco;
    end
  end

  assign asrt_count = cnt;

  a_r11_div_width: assert property (@(posedge clk) disable iff (rst)
    div_rst_o |=> !div_rst_o);
  a_r11_nco_width: assert property (@(posedge clk) disable iff (rst)
    nco_rst_o |=> !nco_rst_o);
  a_r4_div_mask: assert property (@(posedge clk) disable iff (rst)
    div_rst_o |-> !$past(cfg_q.mask_div));
  a_r7_nco_mask: assert property (@(posedge clk) disable iff (rst)
    (nco_rst_o || lmfc_rst_o) |-> !$past(cfg_q.mask_nco));
  a_r5_nco_gate: assert property (@(posedge clk) disable iff (rst)
    nco_rst_o |-> ($past(cnt) >= CNT_W'(NCO_SKIP)) && !$past(cnt_clr));
  a_r6_pair: assert property (@(posedge clk) disable iff (rst)
    nco_rst_o == lmfc_rst_o);
endmodule

// File: tb/tb_sysref_distrib.sv
module tb_sysref_distrib;
  logic       clk = 1'b0;
  logic       rst;
  logic       sysref_pin;
  logic       cfg_wr;
  logic [2:0] cfg_wdata;
  logic       cnt_clr;
  logic       div_rst_o, nco_rst_o, lmfc_rst_o;
  logic [1:0] asrt_count;

  int checks = 0, errors = 0;
  int n_div = 0, n_nco = 0, n_lmfc = 0, n_wide = 0;
  logic p_div = 0, p_nco = 0, p_lmfc = 0;
  logic md = 0, mn = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysref_distrib dut (
    .clk(clk), .rst(rst), .sysref_pin(sysref_pin), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cnt_clr(cnt_clr), .div_rst_o(div_rst_o),
    .nco_rst_o(nco_rst_o), .lmfc_rst_o(lmfc_rst_o), .asrt_count(asrt_count)
  );

  always @(negedge clk) begin
    if (!rst) begin
      n_div  += int'(div_rst_o);
      n_nco  += int'(nco_rst_o);
      n_lmfc += int'(lmfc_rst_o);
      if ((div_rst_o && p_div) || (nco_rst_o && p_nco) || (lmfc_rst_o && p_lmfc))
        n_wide++;
    end
    p_div = div_rst_o; p_nco = nco_rst_o; p_lmfc = lmfc_rst_o;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic m_d, logic m_n);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = {m_n, m_d, a};
    md = m_d; mn = m_n;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pin_pulse();
    @(negedge clk); sysref_pin = 1'b1;
    idle(4);
    sysref_pin = 1'b0;
    idle(6);
  endtask

  task automatic reg_pulse();
    wr(1'b1, md, mn);
    wr(1'b0, md, mn);
    idle(5);
  endtask

  task automatic soft_clear();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    idle(2);
  endtask

  task automatic t_reset();
    check("R1 div", int'(div_rst_o), 0);
    check("R1 nco", int'(nco_rst_o), 0);
    check("R1 lmfc", int'(lmfc_rst_o), 0);
    check("R1 count", int'(asrt_count), 0);
  endtask

  task automatic t_sequence();
    int d0, n0, l0;
    d0 = n_div; n0 = n_nco; l0 = n_lmfc;
    pin_pulse();
    check("R4 first div", n_div - d0, 1);
    check("R5 first nco", n_nco - n0, 0);
    check("R5 first count", int'(asrt_count), 1);
    reg_pulse();
    check("R3 reg div", n_div - d0, 2);
    check("R5 second nco", n_nco - n0, 0);
    check("R5 second lmfc", n_lmfc - l0, 0);
    pin_pulse();
    check("R6 third nco", n_nco - n0, 1);
    check("R6 third lmfc", n_lmfc - l0, 1);
    check("R6 third count", int'(asrt_count), 3);
    reg_pulse();
    check("R6 fourth nco", n_nco - n0, 2);
    check("R8 saturate", int'(asrt_count), 3);
    pin_pulse();
    check("R8 still saturated", int'(asrt_count), 3);
    check("R6 fifth lmfc", n_lmfc - l0, 3);
  endtask

  task automatic t_latency();
    soft_clear();
    @(negedge clk); sysref_pin = 1'b1;
    @(negedge clk); check("R2 lat1", int'(div_rst_o), 0);
    @(negedge clk); check("R2 lat2", int'(div_rst_o), 0);
    @(negedge clk); check("R2 lat3", int'(div_rst_o), 1);
    idle(10);
    check("R2 held level count", int'(asrt_count), 1);
    sysref_pin = 1'b0; idle(5);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = {mn, md, 1'b1};
    @(negedge clk); cfg_wr = 1'b0; check("R3 lat1", int'(div_rst_o), 0);
    @(negedge clk); check("R3 lat2", int'(div_rst_o), 1);
    idle(3);
    wr(1'b1, md, mn); idle(4);
    check("R3 rewrite one ignored", int'(asrt_count), 2);
    wr(1'b0, md, mn); idle(4);
    check("R3 clear bit ignored", int'(asrt_count), 2);
  endtask

  task automatic t_coincide();
    int d0;
    soft_clear();
    d0 = n_div;
    @(negedge clk); sysref_pin = 1'b1;
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = {mn, md, 1'b1};
    @(negedge clk); cfg_wr = 1'b0;
    idle(6);
    check("R10 one div strobe", n_div - d0, 1);
    check("R10 one count", int'(asrt_count), 1);
    sysref_pin = 1'b0;
    wr(1'b0, md, mn); idle(5);
  endtask

  task automatic t_masks();
    int d0, n0, l0;
    soft_clear();
    wr(1'b0, 1'b1, 1'b0);
    d0 = n_div;
    pin_pulse(); pin_pulse();
    check("R4 masked div", n_div - d0, 0);
    check("R4 masked still counted", int'(asrt_count), 2);
    wr(1'b0, 1'b0, 1'b1);
    d0 = n_div; n0 = n_nco; l0 = n_lmfc;
    pin_pulse(); reg_pulse();
    check("R7 nco blocked", n_nco - n0, 0);
    check("R7 lmfc blocked", n_lmfc - l0, 0);
    check("R7 div unaffected", n_div - d0, 2);
    check("R7 counted", int'(asrt_count), 3);
    wr(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_clear();
    int d0, n0;
    soft_clear();
    check("R9 clear", int'(asrt_count), 0);
    pin_pulse(); pin_pulse(); pin_pulse();
    check("R9 refill", int'(asrt_count), 3);
    d0 = n_div; n0 = n_nco;
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 3'b001;
    @(negedge clk); cfg_wr = 1'b0; cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    idle(4);
    check("R9 clear with assertion count", int'(asrt_count), 1);
    check("R9 clear with assertion div", n_div - d0, 1);
    check("R9 clear with assertion nco", n_nco - n0, 0);
    wr(1'b0, 1'b0, 1'b0); idle(3);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; sysref_pin = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; cnt_clr = 1'b0;
    idle(4);
    t_reset();
    @(negedge clk); rst = 1'b0;
    idle(2);
    t_sequence();
    t_latency();
    t_coincide();
    t_masks();
    t_clear();
    check("R11 strobe width", n_wide, 0);
    done = 1;
    finish_run();
  end
endmodule